// File: doc/BRIEF.md
# Pattern Compare Memory Self-Test Engine

This engine exercises a small memory through a synchronous request port. When its enable goes high, it runs a number of test loops. Each loop writes a pattern to every word of the tested range in ascending order, then reads every word back in the same order. On every read it compares the returned word with the expected pattern, using only the bits that the mask selects. The loops alternate between two pattern phases, A and B. Each phase has its own compare value and its own mask. The compare value is also the data that phase writes, so programming phase B as the bitwise complement of phase A gives the usual checkerboard pair: 0xAAAAAAAA for the first phase and 0x55555555 for the second, with matching masks.

Software sets the loop count and the two compare/mask pairs, raises the enable and polls the done flag. It then reads the failure count and drops the enable. Dropping the enable clears the engine, so it is ready for the next run. Dropping it in the middle of a run aborts that run.

Top module: `patt_bist`

## Requirements
- R1: While reset is asserted and in the first cycle after it, done is 0, fail_cnt is 0 and mem_req is 0.
- R2: A run starts on the first clock edge at which en is high and the engine is idle. The loop count is taken from loop_cfg at that edge, and a loop_cfg of 0 selects the default of 8 loops.
- R3: Each loop first writes words 0 to DEPTH-1 in ascending order (mem_we = 1) and then reads them in the same order (mem_we = 0). Loops with an even index, starting at index 0, use phase A: they write cmp_a and compare against cmp_a under mask_a. Loops with an odd index use phase B in the same way, with cmp_b and mask_b.
- R4: mem_rdata is sampled in the cycle after a read request. A bit takes part in the comparison only where the phase mask bit is 1. A read word with one or more masked mismatching bits adds exactly one to fail_cnt.
- R5: done goes high at the sample point L*(2*DEPTH+1)+1 cycles after en was raised, where L is the loop count of the run. The final fail_cnt is already visible in that same cycle.
- R6: While done and en are both high, done stays high, fail_cnt does not change and mem_req stays 0.
- R7: fail_cnt saturates at 2^FAIL_W-1 and does not wrap.
- R8: A cycle in which en is low clears done and fail_cnt at the next edge and aborts any run in progress. The next run starts from loop 0 with a count of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Enable: starts a run; low clears and aborts |
| loop_cfg | input | LOOP_W | Number of loops; 0 selects the default of 8 |
| cmp_a | input | DW | Phase A write and compare value |
| mask_a | input | DW | Phase A compare mask |
| cmp_b | input | DW | Phase B write and compare value |
| mask_b | input | DW | Phase B compare mask |
| mem_req | output | 1 | Memory request strobe |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Word address |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid one cycle after a read request |
| done | output | 1 | Run finished (sticky until en is low) |
| fail_cnt | output | FAIL_W | Number of failing word compares, saturating |

## Verification
A corrupted address or loop counter shows up on the request port within a single pass. The address and write-enable sequence would leave its ascending write-then-read order, or the write data would take the wrong phase, well before done. A miscounted loop total or a stuck sequencer state only shows up at the end, as done rising in the wrong cycle. A fault in the compare path or the counter shows up as a wrong fail_cnt in the first done cycle. Random fault masks and random masks make sure masked-off and multi-bit mismatches are all exercised.

// File: rtl/patt_bist_pkg.sv
package patt_bist_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WRITE = 3'd1,
    ST_READ  = 3'd2,
    ST_CHECK = 3'd3,
    ST_DONE  = 3'd4
  } bist_st_e;

endpackage

// File: rtl/patt_bist_seq.sv
module patt_bist_seq
  import patt_bist_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int AW        = 4,
  parameter int LOOP_W    = 8,
  parameter int DEF_LOOPS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [LOOP_W-1:0] loop_cfg,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic              phase_b,
  output logic              done
);

  localparam logic [AW-1:0]     LAST_ADDR = AW'(DEPTH - 1);
  localparam logic [LOOP_W-1:0] DEF_CNT   = LOOP_W'(DEF_LOOPS);

  bist_st_e          st_q;
  logic [AW-1:0]     addr_q;
  logic [LOOP_W-1:0] loop_idx_q;
  logic [LOOP_W-1:0] loop_tot_q;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      st_q       <= ST_IDLE;
      addr_q     <= '0;
      loop_idx_q <= '0;
      loop_tot_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          loop_tot_q <= (loop_cfg == '0) ? DEF_CNT : loop_cfg;
          st_q       <= ST_WRITE;
        end
        ST_WRITE: begin
          if (addr_q == LAST_ADDR) begin
            addr_q <= '0;
            st_q   <= ST_READ;
          end else begin
            addr_q <= addr_q + 1'b1;
          end
        end
        ST_READ: begin
          if (addr_q == LAST_ADDR) begin
            addr_q <= '0;
            st_q   <= ST_CHECK;
          end else begin
            addr_q <= addr_q + 1'b1;
          end
        end
        ST_CHECK: begin
          if (loop_idx_q == loop_tot_q - 1'b1) begin
            st_q <= ST_DONE;
          end else begin
            loop_idx_q <= loop_idx_q + 1'b1;
            st_q       <= ST_WRITE;
          end
        end
        ST_DONE: st_q <= ST_DONE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_req  = (st_q == ST_WRITE) || (st_q == ST_READ);
  assign mem_we   = (st_q == ST_WRITE);
  assign mem_addr = addr_q;
  assign phase_b  = loop_idx_q[0];
  assign done     = (st_q == ST_DONE);

  // R6: the finished state holds while enabled and issues no traffic
  p_done_holds_r6: assert property (@(posedge clk) disable iff (rst)
    (done && en) |=> (done && !mem_req))
    else $error("done dropped or traffic issued while enabled");

  // R3: a read pass only follows a complete write pass
  p_read_after_write_r3: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_we && mem_addr == '0 && en) |-> $past(mem_req && mem_we))
    else $error("read pass not preceded by write");

endmodule

// File: rtl/patt_bist_cmp.sv
module patt_bist_cmp #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          rd_issue,
  input  logic          phase_b,
  input  logic [DW-1:0] cmp_a,
  input  logic [DW-1:0] mask_a,
  input  logic [DW-1:0] cmp_b,
  input  logic [DW-1:0] mask_b,
  input  logic [DW-1:0] rdata,
  output logic          fail_hit
);

  logic          pend_q;
  logic [DW-1:0] exp_q;
  logic [DW-1:0] msk_q;
  logic [DW-1:0] diff_bits;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      pend_q <= 1'b0;
      exp_q  <= '0;
      msk_q  <= '0;
    end else begin
      pend_q <= rd_issue;
      exp_q  <= phase_b ? cmp_b : cmp_a;
      msk_q  <= phase_b ? mask_b : mask_a;
    end
  end

  genvar gi;
  generate
    for (gi = 0; gi < DW; gi++) begin : g_bit
      assign diff_bits[gi] = msk_q[gi] & (rdata[gi] ^ exp_q[gi]);
    end
  endgenerate

  assign fail_hit = pend_q && (|diff_bits);

  // R4: a failure is only reported in the cycle after a read request
  p_hit_after_read_r4: assert property (@(posedge clk) disable iff (rst)
    fail_hit |-> $past(rd_issue))
    else $error("compare result without a read");

endmodule

// File: rtl/patt_bist_cnt.sv
module patt_bist_cnt #(
  parameter int FAIL_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              inc,
  output logic [FAIL_W-1:0] cnt
);

  localparam logic [FAIL_W-1:0] CNT_MAX = '1;

  logic [FAIL_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
    end else if (inc && cnt_q != CNT_MAX) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt = cnt_q;

  // R7: a full counter stays full until cleared
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
    (cnt == CNT_MAX && !clr) |=> (cnt == CNT_MAX))
    else $error("failure counter wrapped");

  // R4: at most one step per cycle
  p_single_step_r4: assert property (@(posedge clk) disable iff (rst)
    !clr |=> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1))
    else $error("failure counter jumped");

endmodule

// File: rtl/patt_bist.sv
module patt_bist #(
  parameter int DW        = 32,
  parameter int DEPTH     = 16,
  parameter int LOOP_W    = 8,
  parameter int DEF_LOOPS = 8,
  parameter int FAIL_W    = 8,
  localparam int AW       = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [LOOP_W-1:0] loop_cfg,
  input  logic [DW-1:0]     cmp_a,
  input  logic [DW-1:0]     mask_a,
  input  logic [DW-1:0]     cmp_b,
  input  logic [DW-1:0]     mask_b,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [DW-1:0]     mem_wdata,
  input  logic [DW-1:0]     mem_rdata,
  output logic              done,
  output logic [FAIL_W-1:0] fail_cnt
);

  logic phase_b;
  logic fail_hit;

  patt_bist_seq #(
    .DEPTH(DEPTH), .AW(AW), .LOOP_W(LOOP_W), .DEF_LOOPS(DEF_LOOPS)
  ) u_seq (
    .clk(clk), .rst(rst), .en(en), .loop_cfg(loop_cfg),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .phase_b(phase_b), .done(done)
  );

  assign mem_wdata = phase_b ? cmp_b : cmp_a;

  patt_bist_cmp #(.DW(DW)) u_cmp (
    .clk(clk), .rst(rst), .en(en),
    .rd_issue(mem_req && !mem_we), .phase_b(phase_b),
    .cmp_a(cmp_a), .mask_a(mask_a), .cmp_b(cmp_b), .mask_b(mask_b),
    .rdata(mem_rdata), .fail_hit(fail_hit)
  );

  patt_bist_cnt #(.FAIL_W(FAIL_W)) u_cnt (
    .clk(clk), .rst(rst), .clr(!en), .inc(fail_hit), .cnt(fail_cnt)
  );

  // R8: disabling clears status on the next edge
  p_clear_on_disable_r8: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!done && fail_cnt == '0))
    else $error("status not cleared by disable");

  // R6: result is frozen once done is reported
  p_result_frozen_r6: assert property (@(posedge clk) disable iff (rst)
    (done && en) |=> $stable(fail_cnt))
    else $error("fail count moved after done");

endmodule

// File: tb/patt_bist_tb_top.sv
module patt_bist_tb_top;

  localparam int DW = 32;
  localparam int DEPTH = 16;
  localparam int AW = 4;
  localparam int LOOP_W = 8;
  localparam int FAIL_W = 8;
  localparam int SAT = (1 << FAIL_W) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic [LOOP_W-1:0] loop_cfg = '0;
  logic [DW-1:0] cmp_a = 32'hAAAAAAAA, mask_a = 32'hAAAAAAAA;
  logic [DW-1:0] cmp_b = 32'h55555555, mask_b = 32'h55555555;
  logic mem_req, mem_we, done;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata = '0;
  logic [FAIL_W-1:0] fail_cnt;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] flt [DEPTH];
  int seq_n = 0;
  bit ord_err = 1'b0;
  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  patt_bist dut_i (
    .clk(clk), .rst(rst), .en(en), .loop_cfg(loop_cfg),
    .cmp_a(cmp_a), .mask_a(mask_a), .cmp_b(cmp_b), .mask_b(mask_b),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .done(done), .fail_cnt(fail_cnt)
  );

  // memory model with read-side fault injection, plus order monitor (R3)
  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      else mem_rdata <= mem[mem_addr] ^ flt[mem_addr];
    end
    if (rst || !en) begin
      seq_n <= 0;
      ord_err <= 1'b0;
    end else if (mem_req) begin
      if (int'(mem_addr) != seq_n % DEPTH) ord_err <= 1'b1;
      if (mem_we != (((seq_n / DEPTH) % 2) == 0)) ord_err <= 1'b1;
      if (mem_we && mem_wdata != ((((seq_n / (2 * DEPTH)) % 2) == 1) ? cmp_b : cmp_a))
        ord_err <= 1'b1;
      seq_n <= seq_n + 1;
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_fails(input int loops);
    int n = 0;
    for (int l = 0; l < loops; l++)
      for (int a = 0; a < DEPTH; a++)
        if (|(flt[a] & ((l % 2) ? mask_b : mask_a))) n++;
    return (n > SAT) ? SAT : n;
  endfunction

  task automatic clear_faults();
    for (int a = 0; a < DEPTH; a++) flt[a] = '0;
  endtask

  task automatic run(input int cfg, input string tag);
    int loops = (cfg == 0) ? 8 : cfg;
    int cyc = 0;
    int expf = exp_fails(loops);
    int exp_cyc = loops * (2 * DEPTH + 1) + 1;
    logic [DW-1:0] last_pat;
    bit hold_ok = 1'b1;
    bit mem_ok = 1'b1;
    logic [FAIL_W-1:0] held;
    loop_cfg = LOOP_W'(cfg);
    @(negedge clk);
    en = 1'b1;
    do begin
      @(negedge clk);
      cyc++;
    end while (!done && cyc < 20000);
    check(cyc == exp_cyc, {"R5 done latency ", tag}, cyc, exp_cyc);
    check(int'(fail_cnt) == expf, {"R4/R7 fail count ", tag}, fail_cnt, expf);
    check(!ord_err, {"R3 request order/data ", tag}, ord_err, 0);
    last_pat = ((loops - 1) % 2) ? cmp_b : cmp_a;
    for (int a = 0; a < DEPTH; a++) if (mem[a] !== last_pat) mem_ok = 1'b0;
    check(mem_ok, {"R3 final memory pattern ", tag}, mem_ok, 1);
    held = fail_cnt;
    repeat (3) begin
      @(negedge clk);
      if (!done || mem_req || fail_cnt != held) hold_ok = 1'b0;
    end
    check(hold_ok, {"R6 done sticky ", tag}, hold_ok, 1);
    en = 1'b0;
    @(negedge clk);
    check(!done && fail_cnt == 0, {"R8 clear on disable ", tag}, fail_cnt, 0);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    clear_faults();
    for (int a = 0; a < DEPTH; a++) mem[a] = '0;
    repeat (3) @(negedge clk);
    check(!done && fail_cnt == 0 && !mem_req, "R1 reset state", fail_cnt, 0);
    rst = 1'b0;
    @(negedge clk);
    check(!done && fail_cnt == 0 && !mem_req, "R1 after reset", mem_req, 0);

    // clean run, even loop count ends in phase B
    run(4, "clean");

    // R4: bit 1 lies only in mask A: counted in loops 0 and 2 of 3
    flt[5] = 32'h0000_0002;
    run(3, "maskA-only");
    check(exp_fails(3) == 2, "R4 bench model sanity", exp_fails(3), 2);

    // R4: multi-bit mismatch counts once; masked-off bits ignored
    clear_faults();
    mask_a = 32'hFFFF0000; mask_b = 32'h00000000;
    flt[2] = 32'hFFFF_FFFF; flt[9] = 32'h0000_FFFF;
    run(2, "masked");
    mask_a = 32'hAAAAAAAA; mask_b = 32'h55555555;

    // R2: zero selects default loop count
    clear_faults();
    flt[0] = 32'h1;
    run(0, "default-8");

    // R7: saturation
    for (int a = 0; a < DEPTH; a++) flt[a] = '1;
    run(20, "saturate");

    // R8: abort mid-run, then clean restart
    loop_cfg = 8'd5;
    @(negedge clk);
    en = 1'b1;
    repeat (60) @(negedge clk);
    check(fail_cnt != 0 && !done, "R8 mid-run activity", fail_cnt, 1);
    en = 1'b0;
    @(negedge clk);
    check(!done && fail_cnt == 0 && !mem_req, "R8 abort clears", fail_cnt, 0);
    run(5, "after-abort");

    // constrained random runs
    for (int it = 0; it < 6; it++) begin
      cmp_a = $urandom();
      cmp_b = ~cmp_a;
      mask_a = $urandom();
      mask_b = $urandom();
      for (int a = 0; a < DEPTH; a++)
        flt[a] = (($urandom() % 4) == 0) ? $urandom() : '0;
      run(1 + int'($urandom() % 7), $sformatf("random%0d", it));
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule